// File: doc/BRIEF.md
# Two-Register I2C Target

This block is an I2C target for an open-drain clock/data pair. A fast system clock samples both bus lines. The target holds two 8-bit control registers, and their bits leave the block as parallel board-level enable and reset signals. A controller reaches each register by its own 7-bit bus address. The two addresses are consecutive: the even one selects register A and the odd one selects register B.

Each transaction carries one address byte and one data byte. The data byte either writes the selected register or reads it back. After that byte the target returns to idle. A STOP seen mid-byte also returns it to idle. A START, including a repeated START, always begins a fresh address phase. The target only ever pulls the data line low or lets it go. It does not stretch the clock.

Top module: `i2c_regpair_slave`

## Requirements
- R1: While the synchronous active-low reset is applied, both control registers read 0 at the ports and the data line is released (`sda_pull` = 0).
- R2: An address byte is 7 address bits MSB first, then a direction bit (0 = write, 1 = read). It is acknowledged by pulling SDA low during the 9th clock when its upper six address bits equal those of `DEV_ADDR`. Address bit 0 then selects the register: 0 selects `ctrl_a`, 1 selects `ctrl_b`.
- R3: An address whose upper six bits differ is not acknowledged (SDA stays high in the 9th clock). A data byte following it changes neither register.
- R4: In a write, the 8 data bits are taken MSB first on SCL rising edges. The byte is acknowledged in the 9th clock, and the selected register shows the byte at its port.
- R5: In a read, the selected register is placed on SDA MSB first, one bit per clock. SDA is released during the 9th clock so the controller can ACK or NACK.
- R6: After one data byte, whether read or written, the target is idle. A further byte in the same transaction is neither acknowledged nor driven, and it changes no register.
- R7: A STOP during the data byte aborts the transfer and leaves the register unchanged. The next transaction is served normally.
- R8: A START in any state, including a repeated START in the middle of a byte, restarts address reception.
- R9: SDA is only pulled low or released, and the pull changes only while the synchronised SCL is low. The target therefore never creates a START or STOP, and SDA is steady for the whole time SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Level of the bus clock line |
| sda_in | input | 1 | Level of the bus data line |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| ctrl_a | output | 8 | Control register A (even address) |
| ctrl_b | output | 8 | Control register B (odd address) |

## Verification
A write carrying address-derived data is sent to every one of the 128 bus addresses. This separates the two answered addresses from the rest and confirms that only the addressed register changes. Sixteen data values with varied bit patterns are written to and read back from both registers, which distinguishes MSB-first order from bit reversal and shows that the two registers are independent. Separate transactions cover an extra byte after the data byte, a STOP inside a data byte and a repeated START inside the address byte. Together these tell a proper return to idle apart from a machine that keeps shifting. Every bit also samples SDA twice while SCL is high, so any change made by the target during that window is caught.

// File: rtl/i2c_rp_pkg.sv
// Shared types for the two-register I2C target.
package i2c_rp_pkg;
    // Top-level protocol state of the target.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } rp_state_t;
endpackage

// File: rtl/i2c_rp_sync.sv
// Multi-stage synchroniser for one asynchronous bus line.
// Assumes the line idles high; resets to 1 so no false edge follows reset.
module i2c_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_s = chain[STAGES-1];
endmodule

// File: rtl/i2c_rp_cond.sv
// Edge and bus-condition detector working on the synchronised SCL and SDA.
// Produces one-cycle pulses for SCL edges, START and STOP.
module i2c_rp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep last cycle's synchronised levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_rp_fsm.sv
// Protocol engine: address match, ACK, write/read of one data byte.
// Assumes pulses from i2c_rp_cond; SDA pull changes only on an SCL fall.
module i2c_rp_fsm
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sda_s,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      start_det,
    input  logic      stop_det,
    output rp_state_t st,
    output logic      sda_pull,
    output logic [7:0] reg_a,
    output logic [7:0] reg_b
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rd_mode;
    logic              sel;
    logic              hit;
    logic [BYTE_W-1:0] cur;

    assign hit = (shreg[7:2] == DEV_ADDR[6:1]);
    assign cur = sel ? reg_b : reg_a;

    // Single sequential process for the whole protocol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '0;
            rd_mode  <= 1'b0;
            sel      <= 1'b0;
            sda_pull <= 1'b0;
            reg_a    <= '0;
            reg_b    <= '0;
        end else if (start_det) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (scl_rise && cnt < LAST_BIT) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST_BIT) begin
                        if (hit) begin
                            sda_pull <= 1'b1;
                            cnt      <= ACK_BIT;
                            rd_mode  <= shreg[0];
                            sel      <= shreg[1];
                        end else begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end
                    end else if (scl_fall && cnt == ACK_BIT) begin
                        st  <= ST_DATA;
                        cnt <= '0;
                        tx  <= cur;
                        sda_pull <= rd_mode ? ~cur[BYTE_W-1] : 1'b0;
                    end
                end
                ST_DATA: begin
                    if (rd_mode) begin
                        if (scl_rise && cnt < LAST_BIT) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_rise && cnt == LAST_BIT) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else if (scl_fall && cnt != '0 && cnt < LAST_BIT) begin
                            sda_pull <= ~tx[BYTE_W-2];
                            tx       <= {tx[BYTE_W-2:0], 1'b0};
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            sda_pull <= 1'b0;
                        end
                    end else begin
                        if (scl_rise && cnt < LAST_BIT) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            sda_pull <= 1'b1;
                            cnt      <= ACK_BIT;
                            if (sel) reg_b <= shreg;
                            else     reg_a <= shreg;
                        end else if (scl_fall && cnt == ACK_BIT) begin
                            sda_pull <= 1'b0;
                            st       <= ST_IDLE;
                            cnt      <= '0;
                        end
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_regpair_slave.sv
// Two-register I2C target: synchronisers, condition detector, protocol engine.
// Assumes clk is at least ~10x the SCL rate; answers DEV_ADDR and DEV_ADDR|1.
module i2c_regpair_slave
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b
);
    logic      scl_s;
    logic      sda_s;
    logic      scl_rise;
    logic      scl_fall;
    logic      start_det;
    logic      stop_det;
    rp_state_t st;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_s(scl_s)
    );

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_s(sda_s)
    );

    i2c_rp_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rp_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .st(st), .sda_pull(sda_pull), .reg_a(ctrl_a), .reg_b(ctrl_b)
    );
endmodule

// File: rtl/i2c_rp_checker.sv
// Protocol checks for the two-register I2C target, bound to the top.
module i2c_rp_checker
    import i2c_rp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input logic      start_det,
    input logic      stop_det,
    input rp_state_t st,
    input logic      sda_pull,
    input logic [7:0] ctrl_a,
    input logic [7:0] ctrl_b
);
    // R8: any START begins address reception on the next cycle.
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    // R7: STOP without START returns to idle.
    a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE));

    // R9: pull changes only follow a cycle with SCL low.
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_s));

    // R6: no pull while idle.
    a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (st != ST_IDLE));

    // R4: register A changes only from the data phase.
    a_r4_rega_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_a) |-> ($past(st) == ST_DATA));

    // R4: register B changes only from the data phase.
    a_r4_regb_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_b) |-> ($past(st) == ST_DATA));
endmodule

bind i2c_regpair_slave i2c_rp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .st(st),
    .sda_pull(sda_pull), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
);

// File: tb/i2c_regpair_slave_test.sv
module i2c_regpair_slave_test;
    localparam logic [6:0] BASE = 7'h2A;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_bus;
    logic [7:0] ctrl_a, ctrl_b;
    int n_chk = 0;
    int n_bad = 0;
    int glitch = 0;
    bit done = 0;
    logic [7:0] exp_a = 8'h00;
    logic [7:0] exp_b = 8'h00;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_regpair_slave #(.DEV_ADDR(BASE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        sda_m = b;
        tick(H);
        scl = 1'b1;
        tick(H / 2);
        seen = sda_bus;
        tick(H / 2);
        if (sda_bus !== seen) glitch++;
        scl = 1'b0;
        tick(2);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(H);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, ack);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b, output logic ack_line);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            b[i] = s;
        end
        bit_xfer(m_ack, ack_line);
    endtask

    function automatic logic is_hit(input logic [6:0] a);
        return a[6:1] == BASE[6:1];
    endfunction

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic ka, kd;
        do_start();
        send_byte({a, 1'b0}, ka);
        send_byte(d, kd);
        do_stop();
        if (is_hit(a)) begin
            chk("R2 address ack", ka, 1'b0);
            chk("R4 data ack", kd, 1'b0);
            if (a[0]) exp_b = d; else exp_a = d;
        end else begin
            chk("R3 address nack", ka, 1'b1);
            chk("R3 data ignored nack", kd, 1'b1);
        end
        chk("R4 ctrl_a", ctrl_a, exp_a);
        chk("R4 ctrl_b", ctrl_b, exp_b);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] expv);
        logic ka, k9;
        logic [7:0] got;
        do_start();
        send_byte({a, 1'b1}, ka);
        recv_byte(1'b1, got, k9);
        do_stop();
        chk("R5 read address ack", ka, 1'b0);
        chk("R5 read data", got, expv);
        chk("R5 released in 9th clock", k9, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic k, k2;
        logic [7:0] got;
        tick(5);
        chk("R1 reset ctrl_a", ctrl_a, 8'h00);
        chk("R1 reset ctrl_b", ctrl_b, 8'h00);
        chk("R1 reset sda released", sda_pull, 1'b0);
        rst_n = 1'b1;
        tick(5);

        // R2 / R3: sweep every bus address with address-derived data.
        for (int a = 0; a < 128; a++) wr(7'(a), 8'(a) ^ 8'hC3);

        // R4 / R5: data patterns to both registers, read back.
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 17) ^ 8'h5A;
            wr({BASE[6:1], 1'(i)}, v);
            rd({BASE[6:1], 1'(i)}, v);
            rd({BASE[6:1], ~1'(i)}, i[0] ? exp_a : exp_b);
        end
        wr({BASE[6:1], 1'b0}, 8'h81);
        wr({BASE[6:1], 1'b1}, 8'h3C);
        rd({BASE[6:1], 1'b0}, 8'h81);
        rd({BASE[6:1], 1'b1}, 8'h3C);

        // R6: extra byte after a write is ignored.
        do_start();
        send_byte({BASE[6:1], 1'b0, 1'b0}, k);
        send_byte(8'h66, k);
        send_byte(8'h99, k2);
        do_stop();
        exp_a = 8'h66;
        chk("R6 extra write byte nack", k2, 1'b1);
        chk("R6 register after extra byte", ctrl_a, 8'h66);

        // R6: extra byte after a read (controller ACKs) is not driven.
        do_start();
        send_byte({BASE[6:1], 1'b1, 1'b1}, k);
        recv_byte(1'b0, got, k2);
        chk("R6 first read byte", got, 8'h3C);
        recv_byte(1'b1, got, k2);
        do_stop();
        chk("R6 extra read byte released", got, 8'hFF);

        // R7: STOP inside the data byte aborts.
        do_start();
        send_byte({BASE[6:1], 1'b0, 1'b0}, k);
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, k2);
        do_stop();
        chk("R7 aborted write leaves register", ctrl_a, 8'h66);
        wr({BASE[6:1], 1'b0}, 8'hA5);
        chk("R7 next transaction served", ctrl_a, 8'hA5);

        // R8: repeated START inside the address byte restarts addressing.
        do_start();
        for (int i = 0; i < 3; i++) bit_xfer(1'b1, k2);
        do_start();
        send_byte({BASE[6:1], 1'b1, 1'b0}, k);
        send_byte(8'h17, k2);
        do_stop();
        exp_b = 8'h17;
        chk("R8 address ack after repeated START", k, 1'b0);
        chk("R8 write after repeated START", ctrl_b, 8'h17);

        // R9: SDA never moved while SCL high.
        chk("R9 sda steady while scl high", glitch, 0);

        // R1: reset mid-run clears both registers.
        rst_n = 1'b0;
        tick(4);
        chk("R1 reset clears ctrl_a", ctrl_a, 8'h00);
        chk("R1 reset clears ctrl_b", ctrl_b, 8'h00);
        rst_n = 1'b1;
        tick(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule